// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Emulator

This block stands in for a 16-bit asynchronous static RAM inside a clocked design. A host drives the usual active-low strobes: chip select, write strobe, output enable and one enable per byte lane. It also drives a 17-bit word address and a 16-bit data bus, which is split into an input half, an output half and a per-lane drive-enable vector. The block samples every host input through a two-flop synchronizer on its fast system clock. It decodes the access type from the synchronized strobes, stores words in a parameterizable array with per-lane writes, and drives read data only on the lanes the host enabled.

A write is open on a lane while chip select, write strobe and that lane's enable are all low. The write commits when the lane's window closes, whichever of those three signals rises first. The address and data committed are those seen in the last sampled cycle before the close, so later bus changes have no effect. The populated depth is `2**MEM_AW` words. An address with any bit set above that range is treated as unpopulated: writes to it are dropped and reads of it return zero.

Top module: `async_sram_emu`

## Requirements
- R1: The array holds `2**MEM_AW` 16-bit words (1024 by default). A word written at an in-range address (all address bits at or above `MEM_AW` zero) reads back unchanged. A write to an out-of-range address changes no word. A read of an out-of-range address returns zero on the enabled lanes.
- R2: When `cs_n` is high, or both bits of `lane_n` are high, `standby_o` is 1, `mode_o` is 0 (standby), `rdata_oe_o` is 0 and `rdata_o` is 0. No write takes place, whatever `we_n` is.
- R3: With `cs_n` low, `we_n` high and `oe_n` low, each lane whose `lane_n` bit is low drives its byte and sets its `rdata_oe_o` bit. Bit 0 is bits 7:0 and bit 1 is bits 15:8. A lane that is not enabled reads 0 with its drive bit clear. `mode_o` is 2 (read).
- R4: With `cs_n` low, `we_n` high, `oe_n` high and at least one lane enabled, no lane is driven, `standby_o` is 0 and `mode_o` is 1 (active, outputs off).
- R5: With `cs_n` low, `we_n` low and at least one lane enabled, `mode_o` is 3 (write) and no lane is driven, whatever `oe_n` is. Only enabled lanes are written.
- R6: A lane's write is committed when its window closes. The window may be closed by `we_n` rising, by `cs_n` rising, or by that lane's enable rising. Address and data changes made in the same cycle as the close, or later, are not stored.
- R7: Each lane's window closes on its own. A lane released early keeps the data it held at its release, while the other lane goes on to take later data.
- R8: Every host input reaches the outputs three clock edges after it changes. Two edges after a change the outputs still show the old state.
- R9: While `rst` is high, and after it falls until new inputs arrive, `standby_o` is 1, `mode_o` is 0 and no lane is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| lane_n | input | 2 | Byte-lane enables, active low; bit 1 upper byte |
| addr_i | input | 17 | Word address |
| wdata_i | input | 16 | Write data from host |
| rdata_o | output | 16 | Read data, zero on undriven lanes |
| rdata_oe_o | output | 2 | Per-lane output drive enable |
| standby_o | output | 1 | High while deselected |
| mode_o | output | 2 | 0 standby, 1 active idle, 2 read, 3 write |

## Verification
The hardest case to reach from the ports is a write window that closes on a lane while new data is already on the bus in the same sampled cycle. The commit must then take the previous cycle's values, and when a single lane is released, the other lane must go on accepting data. The bench ends every write by a randomly chosen strobe and swaps the address and data on the bus in that same cycle. It also runs a directed sequence that releases the upper lane first, changes the data, and then closes the lower lane with the write strobe. Random reads against a bench model, done after a full preload of the array, then show which values were actually stored.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_IDLE    = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } mode_e;
endpackage

// File: rtl/sram_emu_sync.sv
module sram_emu_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/sram_emu_decode.sv
module sram_emu_decode
  import sram_emu_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             cs_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] lane_win,
  output logic [LANES-1:0] lane_rd,
  output logic             standby,
  output mode_e            mode
);
  logic selected;

  assign selected = !cs_n && !(&lane_n);
  assign standby  = !selected;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_win[g] = !cs_n && !we_n && !lane_n[g];
    assign lane_rd[g]  = !cs_n &&  we_n && !oe_n && !lane_n[g];
  end

  always_comb begin
    if (!selected)  mode = MODE_STANDBY;
    else if (!we_n) mode = MODE_WRITE;
    else if (!oe_n) mode = MODE_READ;
    else            mode = MODE_IDLE;
  end
endmodule

// File: rtl/sram_emu_lane.sv
module sram_emu_lane #(
  parameter int AW = 10,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          win,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic          addr_ok,
  input  logic [BW-1:0] wdata,
  output logic [BW-1:0] rdata_o,
  output logic          oe_o
);
  localparam int DEPTH = 1 << AW;

  logic [BW-1:0] mem [DEPTH];
  logic          win_q;
  logic [AW-1:0] cap_addr;
  logic [BW-1:0] cap_data;
  logic          cap_ok;
  logic [BW-1:0] rd_word;
  logic          rd_ok_q;
  logic          commit;

  // Window close: the lane was open last cycle and is not open now.
  assign commit = win_q && !win;

  always_ff @(posedge clk) begin
    if (win) begin
      cap_addr <= addr;
      cap_data <= wdata;
      cap_ok   <= addr_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (commit && cap_ok) mem[cap_addr] <= cap_data;
    rd_word <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q   <= 1'b0;
      oe_o    <= 1'b0;
      rd_ok_q <= 1'b0;
    end else begin
      win_q   <= win;
      oe_o    <= rd;
      rd_ok_q <= addr_ok;
    end
  end

  assign rdata_o = (oe_o && rd_ok_q) ? rd_word : '0;
endmodule

// File: rtl/async_sram_emu.sv
module async_sram_emu
  import sram_emu_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANE_W = 8,
  parameter int MEM_AW = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cs_n,
  input  logic                       we_n,
  input  logic                       oe_n,
  input  logic [DATA_W/LANE_W-1:0]   lane_n,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [DATA_W/LANE_W-1:0]   rdata_oe_o,
  output logic                       standby_o,
  output logic [1:0]                 mode_o
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int CTL_W = 3 + LANES;

  logic [CTL_W-1:0]  ctl_s;
  logic              cs_s, we_s, oe_s;
  logic [LANES-1:0]  lane_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] wdata_s;
  logic              addr_ok;
  logic [LANES-1:0]  lane_win, lane_rd;
  logic              standby_c;
  mode_e             mode_c;
  mode_e             mode_q;

  sram_emu_sync #(.W(CTL_W), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
    .clk(clk), .rst(rst), .d({cs_n, we_n, oe_n, lane_n}), .q(ctl_s)
  );
  sram_emu_sync #(.W(ADDR_W), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst(rst), .d(addr_i), .q(addr_s)
  );
  sram_emu_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_data (
    .clk(clk), .rst(rst), .d(wdata_i), .q(wdata_s)
  );

  assign {cs_s, we_s, oe_s, lane_s} = ctl_s;

  if (MEM_AW < ADDR_W) begin : g_range
    assign addr_ok = ~|addr_s[ADDR_W-1:MEM_AW];
  end else begin : g_full
    assign addr_ok = 1'b1;
  end

  sram_emu_decode #(.LANES(LANES)) u_decode (
    .cs_n(cs_s), .we_n(we_s), .oe_n(oe_s), .lane_n(lane_s),
    .lane_win(lane_win), .lane_rd(lane_rd),
    .standby(standby_c), .mode(mode_c)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_emu_lane #(.AW(MEM_AW), .BW(LANE_W)) u_lane (
      .clk(clk), .rst(rst),
      .win(lane_win[g]), .rd(lane_rd[g]),
      .addr(addr_s[MEM_AW-1:0]), .addr_ok(addr_ok),
      .wdata(wdata_s[g*LANE_W +: LANE_W]),
      .rdata_o(rdata_o[g*LANE_W +: LANE_W]),
      .oe_o(rdata_oe_o[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      standby_o <= 1'b1;
      mode_q    <= MODE_STANDBY;
    end else begin
      standby_o <= standby_c;
      mode_q    <= mode_c;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/async_sram_emu_chk.sv
module async_sram_emu_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             standby_o,
  input logic [1:0]       mode_o,
  input logic [LANES-1:0] rdata_oe_o
);
  // R2: deselected means no lane is driven and the mode reads standby
  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (rst)
    standby_o |-> (rdata_oe_o == '0 && mode_o == 2'd0));

  // R2: the standby mode code only ever appears together with the flag
  a_r2_mode_flag: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd0) |-> standby_o);

  // R3: any lane driven implies read mode
  a_r3_drive_in_read: assert property (@(posedge clk) disable iff (rst)
    (|rdata_oe_o) |-> (mode_o == 2'd2));

  // R4: active with outputs disabled drives nothing
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd1) |-> (rdata_oe_o == '0 && !standby_o));

  // R5: a write never drives the bus
  a_r5_write_quiet: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 2'd3) |-> (rdata_oe_o == '0));

  // R9: the first cycle after reset shows the quiet state
  a_r9_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (standby_o && rdata_oe_o == '0));
endmodule

bind async_sram_emu async_sram_emu_chk #(.LANES(DATA_W / LANE_W)) u_chk (
  .clk(clk), .rst(rst), .standby_o(standby_o),
  .mode_o(mode_o), .rdata_oe_o(rdata_oe_o)
);

// File: tb/async_sram_emu_bench.sv
module async_sram_emu_bench;
  localparam int MEM_AW = 10;
  localparam int DEPTH  = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [1:0]  lane_n = 2'b11;
  logic [16:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  rdata_oe_o;
  logic        standby_o;
  logic [1:0]  mode_o;

  logic [15:0] model [DEPTH];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  async_sram_emu #(.MEM_AW(MEM_AW)) u_async_sram_emu (
    .clk(clk), .rst(rst), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .lane_n(lane_n), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o),
    .standby_o(standby_o), .mode_o(mode_o)
  );

  function automatic logic [15:0] lane_mask(input logic [1:0] ln);
    return {{8{~ln[1]}}, {8{~ln[0]}}};
  endfunction

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                        input logic [1:0] ln);
    return (old & ~lane_mask(ln)) | (nw & lane_mask(ln));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle();
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lane_n = 2'b11;
    wait_n(4);
  endtask

  // endby: 0 write strobe, 1 chip select, 2 lane enables
  task automatic do_write(input logic [16:0] a, input logic [15:0] d,
                          input logic [1:0] ln, input int endby, input logic csv);
    logic [1:0] exp_mode;
    addr_i = a; wdata_i = d; lane_n = ln; cs_n = csv; we_n = 1'b0;
    oe_n = 1'($urandom_range(0, 1));
    wait_n(4);
    exp_mode = (csv || ln == 2'b11) ? 2'd0 : 2'd3;
    chk(mode_o == exp_mode && rdata_oe_o == 2'b00, "R5 write mode/no drive",
        {rdata_oe_o, mode_o}, {2'b00, exp_mode});
    case (endby)
      0: we_n = 1'b1;
      1: cs_n = 1'b1;
      default: lane_n = 2'b11;
    endcase
    wdata_i = ~d;
    addr_i  = a ^ 17'h00155;
    wait_n(4);
    if (!csv && a[16:MEM_AW] == '0)
      model[a[MEM_AW-1:0]] = merge(model[a[MEM_AW-1:0]], d, ln);
    go_idle();
  endtask

  task automatic do_read(input logic [16:0] a, input logic [1:0] ln, input string req);
    logic [15:0] exp_d;
    logic [1:0]  exp_oe;
    addr_i = a; lane_n = ln; cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b0;
    wait_n(2);
    chk(rdata_oe_o == 2'b00, "R8 not yet driven after two edges", {30'd0, rdata_oe_o}, 32'd0);
    wait_n(1);
    exp_oe = ~ln;
    exp_d  = (a[16:MEM_AW] == '0) ? (model[a[MEM_AW-1:0]] & lane_mask(ln)) : 16'h0000;
    chk(rdata_oe_o == exp_oe, {req, " lane drive"}, {30'd0, rdata_oe_o}, {30'd0, exp_oe});
    chk(rdata_o == exp_d, {req, " read data"}, {16'd0, rdata_o}, {16'd0, exp_d});
    chk(mode_o == ((ln == 2'b11) ? 2'd0 : 2'd2), "R3 read mode", {30'd0, mode_o},
        (ln == 2'b11) ? 32'd0 : 32'd2);
    go_idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [16:0] a;
    logic [15:0] d;
    logic [15:0] d1, d2, d3;
    void'($urandom(32'd20240611));
    wait_n(3);
    // R9: reset state
    chk(standby_o == 1'b1 && mode_o == 2'd0 && rdata_oe_o == 2'b00, "R9 reset state",
        {28'd0, standby_o, mode_o, rdata_oe_o}, {28'd0, 1'b1, 2'd0, 2'b00});
    rst = 1'b0;
    wait_n(2);
    chk(standby_o == 1'b1 && rdata_oe_o == 2'b00, "R9 after reset",
        {30'd0, standby_o, 1'b0}, {30'd0, 1'b1, 1'b0});

    // R1: preload the array, closing each write by a rotating strobe
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 16'h0000;
      do_write(17'(i), 16'(i * 16'h9E37 + 16'h1234), 2'b00, i % 3, 1'b0);
    end
    for (int i = 0; i < 8; i++) do_read(17'(i * 131), 2'b00, "R1 preload");

    // R4: selected, outputs disabled
    cs_n = 1'b0; we_n = 1'b1; oe_n = 1'b1; lane_n = 2'b00;
    wait_n(4);
    chk(mode_o == 2'd1 && rdata_oe_o == 2'b00 && standby_o == 1'b0, "R4 output disabled",
        {28'd0, standby_o, mode_o, rdata_oe_o}, {28'd0, 1'b0, 2'd1, 2'b00});
    go_idle();

    // R2: deselect by chip select, then by both lanes
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b0; lane_n = 2'b00;
    wait_n(4);
    chk(standby_o && mode_o == 2'd0 && rdata_oe_o == 2'b00 && rdata_o == 16'h0, "R2 cs high",
        {11'd0, standby_o, mode_o, rdata_oe_o, rdata_o}, {11'd0, 1'b1, 2'd0, 2'b00, 16'h0});
    cs_n = 1'b0; lane_n = 2'b11;
    wait_n(4);
    chk(standby_o && mode_o == 2'd0 && rdata_oe_o == 2'b00, "R2 both lanes off",
        {28'd0, standby_o, mode_o, rdata_oe_o}, {28'd0, 1'b1, 2'd0, 2'b00});
    go_idle();

    // R2: writes while deselected are ignored
    do_write(17'd5, 16'hDEAD, 2'b11, 0, 1'b0);
    do_write(17'd6, 16'hBEEF, 2'b00, 0, 1'b1);
    do_read(17'd5, 2'b00, "R2 write ignored lanes off");
    do_read(17'd6, 2'b00, "R2 write ignored cs high");

    // R1: out-of-range write leaves the aliased word, out-of-range read gives zero
    do_write(17'h10007, 16'hA5A5, 2'b00, 0, 1'b0);
    do_read(17'd7, 2'b00, "R1 out-of-range write dropped");
    do_read(17'h10007, 2'b00, "R1 out-of-range read zero");

    // R6: each closing strobe, bus changed in the closing cycle
    do_write(17'd20, 16'h1111, 2'b00, 0, 1'b0);
    do_read(17'd20, 2'b00, "R6 closed by write strobe");
    do_write(17'd21, 16'h2222, 2'b00, 1, 1'b0);
    do_read(17'd21, 2'b00, "R6 closed by chip select");
    do_write(17'd22, 16'h3333, 2'b00, 2, 1'b0);
    do_read(17'd22, 2'b00, "R6 closed by lane enables");

    // R3/R5: single-lane write and single-lane reads
    do_write(17'd30, 16'h7788, 2'b01, 0, 1'b0);
    do_read(17'd30, 2'b01, "R3 upper lane only");
    do_read(17'd30, 2'b10, "R3 lower lane only");

    // R7: upper lane released first, lower lane keeps taking data
    d1 = 16'hC3A1; d2 = 16'h5AB2; d3 = 16'h0FF3;
    addr_i = 17'd40; wdata_i = d1; lane_n = 2'b00; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    wait_n(4);
    lane_n = 2'b10; wdata_i = d2;
    wait_n(4);
    we_n = 1'b1; wdata_i = d3;
    wait_n(4);
    model[40] = {d1[15:8], d2[7:0]};
    go_idle();
    do_read(17'd40, 2'b00, "R7 independent lane close");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      a = ($urandom_range(0, 15) == 0) ? 17'($urandom) : 17'($urandom_range(0, DEPTH - 1));
      d = 16'($urandom);
      if ($urandom_range(0, 1) == 0)
        do_write(a, d, 2'($urandom_range(0, 3)), int'($urandom_range(0, 2)), 1'b0);
      else
        do_read(a, 2'($urandom_range(0, 3)), "R1 random read");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule